// File: doc/BRIEF.md
# Volume Fade Ramp Sequencer

This block owns the gain code of a stereo power amplifier. It follows a 5-bit target code from a quantized volume input. Code 0 is mute and code 31 is the loudest setting, and the steps above mute are 2 dB apart. When the amplifier is put into shutdown or brought out of it, the block either walks the gain one code at a time or jumps it in a single cycle. A fade-select input picks which. The block also orders the gain against the charge and discharge of the bias reference. Gain is never above mute while the reference is off. In the gradual cases, the reference is discharged only after the gain has reached mute, and the gain rises only after the reference reports ready.

A slow tick paces every ramp: one code per two ticks. After reset the block always charges the reference and ramps up from mute, whatever the fade select says. A request that reverses in the middle of a ramp turns the ramp around from the code it has reached. A single-ended select reports headphone mode, turns off the negative output stage, and caps the gain three codes (6 dB) below the bridged maximum. The analog gain network, the volume converter and the bias capacitor are outside the block and appear only as the ready and empty flags.

Top module: `gain_fade_seq`

## Requirements
- R1: While reset is held, the sequencer state is CHARGING (state code 1), the gain code is 0 and bias_en is 1. After reset the gain ramps up to the target once bias_ready is seen, even with fade_n high.
- R2: In RAMP_UP (2) and RAMP_DOWN (4), the gain moves by exactly one code on every second tick. A tick in the same cycle as a state change is not counted. The first step falls on the second counted tick after the state is entered.
- R3: With fade_n low, a fall of shutdown_n in ACTIVE (3) steps the gain down to 0. From code 31 this takes 62 ticks. The state moves to DISCHARGING (5), with bias_en low, only on the cycle after the gain reads 0.
- R4: With fade_n low, a rise of shutdown_n in OFF (0) or DISCHARGING enters CHARGING. There bias_en is high and the gain stays 0 until bias_ready. The gain then ramps up to the target and the state becomes ACTIVE.
- R5: With fade_n high, a fall of shutdown_n in ACTIVE sets the gain to 0, drops bias_en and enters DISCHARGING, all on the next clock edge.
- R6: With fade_n high and the power-up ramp finished, a rise of shutdown_n waits in CHARGING for bias_ready. It then loads the target in one cycle, with no intermediate codes.
- R7: One cycle after se_sel is sampled high, se_mode is 1 and neg_out_en is 0. While se_sel is high, the gain never exceeds code 28.
- R8: In ACTIVE, a new target code appears on gain_code on the next clock edge.
- R9: A rise of shutdown_n during RAMP_DOWN enters RAMP_UP from the current code. A fall during RAMP_UP with fade_n low enters RAMP_DOWN from the current code.
- R10: In DISCHARGING, bias_empty moves the state to OFF. done is high for exactly the first cycle of each stay in ACTIVE or OFF.
- R11: mute is high exactly when gain_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| tick | input | 1 | Slow pacing pulse, one clock wide |
| shutdown_n | input | 1 | Low requests shutdown |
| fade_n | input | 1 | Low selects gradual transitions, high selects immediate |
| se_sel | input | 1 | High selects single-ended (headphone) output |
| target_code | input | 5 | Quantized volume target |
| bias_ready | input | 1 | Bias reference has reached its working level |
| bias_empty | input | 1 | Bias reference is fully discharged |
| gain_code | output | 5 | Current gain code |
| mute | output | 1 | Gain is at code 0 |
| bias_en | output | 1 | Enables charging of the bias reference (low discharges it) |
| se_mode | output | 1 | Single-ended mode reported |
| neg_out_en | output | 1 | Enables the negative output stage |
| seq_state | output | 3 | Sequencer state code |
| done | output | 1 | One-cycle pulse on entering ACTIVE or OFF |

## Verification
The hardest case to reach is a reversal in the middle of a ramp. shutdown_n has to flip while the gain sits at a code between the ends, and the pacing phase is then part-way through a step. The stimulus starts a gradual shutdown from full gain. It polls the gain code until it has dropped a few codes, then raises shutdown_n again. A behavioural reference model checks the new ramp on every cycle. Counting the 62 ticks of a full ramp-down needs the tick pulses to be seen relative to state entry. The bench counts only the ticks that fall while the model is in RAMP_DOWN above mute.

// File: rtl/gfs_pkg.sv
package gfs_pkg;

  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_CHARGING  = 3'd1,
    ST_RAMP_UP   = 3'd2,
    ST_ACTIVE    = 3'd3,
    ST_RAMP_DOWN = 3'd4,
    ST_DISCHARGE = 3'd5
  } gfs_state_e;

  // The reference stays enabled in every state in which gain may be nonzero.
  function automatic logic bias_wanted(input gfs_state_e st);
    return (st == ST_CHARGING) || (st == ST_RAMP_UP) ||
           (st == ST_ACTIVE)   || (st == ST_RAMP_DOWN);
  endfunction

  // A state is an end point of a sequence when done should pulse on entry.
  function automatic logic is_end_state(input gfs_state_e st);
    return (st == ST_ACTIVE) || (st == ST_OFF);
  endfunction

endpackage

// File: rtl/gfs_pacer.sv
module gfs_pacer (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  output logic step_ok
);

  logic phase_q;

  // A step is granted on the second tick of each pair.
  assign step_ok = tick & phase_q & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= 1'b0;
    else if (restart) phase_q <= 1'b0;
    else if (tick)    phase_q <= ~phase_q;
  end

endmodule

// File: rtl/gfs_ceiling.sv
module gfs_ceiling #(
  parameter int CODE_W  = 5,
  parameter int SE_DROP = 3
) (
  input  logic              se_sel,
  input  logic [CODE_W-1:0] target_code,
  output logic [CODE_W-1:0] eff_target
);

  localparam int MAX_CODE = (1 << CODE_W) - 1;
  localparam logic [CODE_W-1:0] SE_MAX = CODE_W'(MAX_CODE - SE_DROP);

  function automatic logic [CODE_W-1:0] clamp_code(input logic se,
                                                   input logic [CODE_W-1:0] t);
    if (se && (t > SE_MAX)) return SE_MAX;
    return t;
  endfunction

  assign eff_target = clamp_code(se_sel, target_code);

endmodule

// File: rtl/gfs_fsm.sv
module gfs_fsm
  import gfs_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shutdown_n,
  input  logic              fade_n,
  input  logic              bias_ready,
  input  logic              bias_empty,
  input  logic              step_ok,
  input  logic [CODE_W-1:0] eff_target,
  output gfs_state_e        state_q,
  output logic [CODE_W-1:0] gain_q,
  output logic              done_q,
  output logic              restart
);

  localparam logic [CODE_W-1:0] ZERO_CODE = '0;
  localparam logic [CODE_W-1:0] ONE_CODE  = CODE_W'(1);

  gfs_state_e        nxt_state;
  logic [CODE_W-1:0] nxt_gain;
  logic              powerup_q;
  logic              nxt_powerup;

  assign restart = (nxt_state != state_q);

  always_comb begin
    nxt_state   = state_q;
    nxt_gain    = gain_q;
    nxt_powerup = powerup_q;
    unique case (state_q)
      ST_OFF: begin
        nxt_gain = ZERO_CODE;
        if (shutdown_n) nxt_state = ST_CHARGING;
      end
      ST_CHARGING: begin
        nxt_gain = ZERO_CODE;
        if (!shutdown_n) begin
          nxt_state = ST_DISCHARGE;
        end else if (bias_ready) begin
          if (fade_n && !powerup_q) begin
            nxt_state = ST_ACTIVE;
            nxt_gain  = eff_target;
          end else begin
            nxt_state = ST_RAMP_UP;
          end
        end
      end
      ST_RAMP_UP: begin
        if (!shutdown_n) begin
          if (fade_n) begin
            nxt_state = ST_DISCHARGE;
            nxt_gain  = ZERO_CODE;
          end else begin
            nxt_state = ST_RAMP_DOWN;
          end
        end else if (gain_q >= eff_target) begin
          nxt_state = ST_ACTIVE;
          nxt_gain  = eff_target;
        end else if (step_ok) begin
          nxt_gain = gain_q + ONE_CODE;
        end
      end
      ST_ACTIVE: begin
        if (!shutdown_n) begin
          if (fade_n) begin
            nxt_state = ST_DISCHARGE;
            nxt_gain  = ZERO_CODE;
          end else begin
            nxt_state = ST_RAMP_DOWN;
          end
        end else begin
          nxt_gain = eff_target;
        end
      end
      ST_RAMP_DOWN: begin
        if (shutdown_n) begin
          nxt_state = ST_RAMP_UP;
        end else if (gain_q == ZERO_CODE) begin
          nxt_state = ST_DISCHARGE;
        end else if (step_ok) begin
          nxt_gain = gain_q - ONE_CODE;
        end
      end
      ST_DISCHARGE: begin
        nxt_gain = ZERO_CODE;
        if (shutdown_n)      nxt_state = ST_CHARGING;
        else if (bias_empty) nxt_state = ST_OFF;
      end
      default: begin
        nxt_state = ST_DISCHARGE;
        nxt_gain  = ZERO_CODE;
      end
    endcase
    if ((nxt_state == ST_ACTIVE) || (nxt_state == ST_RAMP_DOWN) ||
        (nxt_state == ST_DISCHARGE))
      nxt_powerup = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_CHARGING;
      gain_q    <= ZERO_CODE;
      done_q    <= 1'b0;
      powerup_q <= 1'b1;
    end else begin
      state_q   <= nxt_state;
      gain_q    <= nxt_gain;
      done_q    <= restart && is_end_state(nxt_state);
      powerup_q <= nxt_powerup;
    end
  end

endmodule

// File: rtl/gain_fade_seq.sv
module gain_fade_seq
  import gfs_pkg::*;
#(
  parameter int CODE_W  = 5,
  parameter int SE_DROP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              shutdown_n,
  input  logic              fade_n,
  input  logic              se_sel,
  input  logic [CODE_W-1:0] target_code,
  input  logic              bias_ready,
  input  logic              bias_empty,
  output logic [CODE_W-1:0] gain_code,
  output logic              mute,
  output logic              bias_en,
  output logic              se_mode,
  output logic              neg_out_en,
  output logic [2:0]        seq_state,
  output logic              done
);

  gfs_state_e        state_q;
  logic [CODE_W-1:0] eff_target;
  logic              step_ok;
  logic              restart;
  logic              se_q;

  gfs_ceiling #(.CODE_W(CODE_W), .SE_DROP(SE_DROP)) u_ceil (
    .se_sel      (se_sel),
    .target_code (target_code),
    .eff_target  (eff_target)
  );

  gfs_pacer u_pace (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .restart (restart),
    .step_ok (step_ok)
  );

  gfs_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .shutdown_n (shutdown_n),
    .fade_n     (fade_n),
    .bias_ready (bias_ready),
    .bias_empty (bias_empty),
    .step_ok    (step_ok),
    .eff_target (eff_target),
    .state_q    (state_q),
    .gain_q     (gain_code),
    .done_q     (done),
    .restart    (restart)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) se_q <= 1'b0;
    else        se_q <= se_sel;
  end

  assign se_mode    = se_q;
  assign neg_out_en = ~se_q;
  assign mute       = (gain_code == '0);
  assign bias_en    = bias_wanted(state_q);
  assign seq_state  = state_q;

endmodule

// File: rtl/gfs_checker.sv
module gfs_checker #(
  parameter int CODE_W  = 5,
  parameter int SE_DROP = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              shutdown_n,
  input logic              fade_n,
  input logic              se_sel,
  input logic [CODE_W-1:0] gain_code,
  input logic [CODE_W-1:0] eff_target,
  input logic              bias_en,
  input logic [2:0]        seq_state,
  input logic              done
);

  localparam logic [CODE_W-1:0] SE_MAX = CODE_W'((1 << CODE_W) - 1 - SE_DROP);

  // R2
  up_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd2 && shutdown_n && !tick && gain_code < eff_target)
      |=> $stable(gain_code));

  // R3
  down_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd4 && !shutdown_n && !tick && gain_code != '0)
      |=> $stable(gain_code));

  // R3
  bias_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bias_en |-> (gain_code == '0));

  // R4
  charge_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd1) |-> (gain_code == '0));

  // R5
  instant_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd3 && !shutdown_n && fade_n)
      |=> (seq_state == 3'd5 && gain_code == '0 && !bias_en));

  // R7
  se_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd3 && se_sel && shutdown_n) |=> (gain_code <= SE_MAX));

  // R10
  done_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (seq_state == 3'd3 || seq_state == 3'd0));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind gain_fade_seq gfs_checker #(.CODE_W(CODE_W), .SE_DROP(SE_DROP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .shutdown_n (shutdown_n),
  .fade_n     (fade_n),
  .se_sel     (se_sel),
  .gain_code  (gain_code),
  .eff_target (eff_target),
  .bias_en    (bias_en),
  .seq_state  (seq_state),
  .done       (done)
);

// File: tb/sim_gain_fade_seq.sv
`timescale 1ns/1ps
module sim_gain_fade_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       shutdown_n = 1'b1;
  logic       fade_n = 1'b1;
  logic       se_sel = 1'b0;
  logic [4:0] target_code = 5'd10;
  logic       bias_ready = 1'b0;
  logic       bias_empty = 1'b0;
  logic [4:0] gain_code;
  logic       mute, bias_en, se_mode, neg_out_en, done;
  logic [2:0] seq_state;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  gain_fade_seq u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .shutdown_n(shutdown_n),
    .fade_n(fade_n), .se_sel(se_sel), .target_code(target_code),
    .bias_ready(bias_ready), .bias_empty(bias_empty),
    .gain_code(gain_code), .mute(mute), .bias_en(bias_en),
    .se_mode(se_mode), .neg_out_en(neg_out_en), .seq_state(seq_state),
    .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st = 1, m_gain = 0, m_phase = 0, m_pu = 1, m_done = 0, m_se = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 1; m_gain = 0; m_phase = 0; m_pu = 1; m_done = 0; m_se = 0;
    end else begin
      int eff, nst, ng;
      bit stp;
      eff = (se_sel && target_code > 28) ? 28 : int'(target_code);
      stp = tick && (m_phase == 1);
      nst = m_st; ng = m_gain;
      if (m_st == 0) begin
        ng = 0; if (shutdown_n) nst = 1;
      end else if (m_st == 1) begin
        ng = 0;
        if (!shutdown_n) nst = 5;
        else if (bias_ready) begin
          if (fade_n && m_pu == 0) begin nst = 3; ng = eff; end
          else nst = 2;
        end
      end else if (m_st == 2) begin
        if (!shutdown_n) begin
          if (fade_n) begin nst = 5; ng = 0; end else nst = 4;
        end else if (m_gain >= eff) begin nst = 3; ng = eff; end
        else if (stp) ng = m_gain + 1;
      end else if (m_st == 3) begin
        if (!shutdown_n) begin
          if (fade_n) begin nst = 5; ng = 0; end else nst = 4;
        end else ng = eff;
      end else if (m_st == 4) begin
        if (shutdown_n) nst = 2;
        else if (m_gain == 0) nst = 5;
        else if (stp) ng = m_gain - 1;
      end else begin
        ng = 0;
        if (shutdown_n) nst = 1; else if (bias_empty) nst = 0;
      end
      if (nst == 3 || nst == 4 || nst == 5) m_pu = 0;
      m_done = (nst != m_st) && (nst == 3 || nst == 0);
      if (nst != m_st) m_phase = 0;
      else if (tick) m_phase = 1 - m_phase;
      m_st = nst; m_gain = ng; m_se = se_sel;
    end
  end

  // Per-cycle comparison against the model (R2 covers the pacing).
  always @(negedge clk) begin
    if (rst_n) begin
      int bexp;
      bexp = (m_st >= 1 && m_st <= 4) ? 1 : 0;
      chk(gain_code == m_gain, "R2 model gain", gain_code, m_gain);
      if (seq_state != m_st) chk(0, "R2 model state", seq_state, m_st);
      if (bias_en != bexp) chk(0, "R3 model bias_en", bias_en, bexp);
      if (done != m_done) chk(0, "R10 model done", done, m_done);
      if (mute != (m_gain == 0)) chk(0, "R11 model mute", mute, m_gain == 0);
      if (se_mode != m_se || neg_out_en == m_se) chk(0, "R7 model se", se_mode, m_se);
    end
  end

  // ---------------- environment: tick, bias reference ----------------
  int tcnt = 0, rcnt = 0, ecnt = 0;
  always @(negedge clk) begin
    tick = (tcnt == 3);
    tcnt = (tcnt + 1) % 4;
    if (bias_en) begin rcnt++; ecnt = 0; end else begin ecnt++; rcnt = 0; end
    bias_ready = (rcnt >= 5);
    bias_empty = (ecnt >= 5);
  end

  // ---------------- monitors ----------------
  int  down_ticks = 0;
  bit  order_bad = 0;
  bit  saw_ramp = 0;
  int  pre_max = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tick && m_st == 4 && m_gain != 0) down_ticks++;
      if (!bias_en && gain_code != 0) order_bad = 1;
      if (seq_state == 3'd2) saw_ramp = 1;
      if (seq_state != 3'd3 && int'(gain_code) > pre_max) pre_max = gain_code;
    end
  end

  task automatic wait_state(input int s);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (seq_state == s) return;
    end
    chk(0, "wait_state timeout", seq_state, s);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(seq_state == 3'd1, "R1 reset state", seq_state, 1);
    chk(gain_code == 0 && bias_en, "R1 reset gain/bias", gain_code, 0);
    rst_n = 1'b1;
    // R1 power-up ramps despite fade_n high
    wait_state(3);
    chk(saw_ramp, "R1 power-up ramp seen", saw_ramp, 1);
    chk(gain_code == 10, "R1 power-up final gain", gain_code, 10);
    chk(done == 1, "R10 done on ACTIVE entry", done, 1);
    // R8 target follow
    target_code = 5'd31;
    @(negedge clk);
    chk(gain_code == 31, "R8 target follow", gain_code, 31);
    repeat (3) @(negedge clk);
    // R3 gradual shutdown from 31
    fade_n = 1'b0; down_ticks = 0; order_bad = 0;
    shutdown_n = 1'b0;
    wait_state(5);
    chk(down_ticks == 62, "R3 ramp-down ticks", down_ticks, 62);
    chk(!order_bad, "R3 bias after mute", order_bad, 0);
    wait_state(0);
    chk(done == 1, "R10 done on OFF entry", done, 1);
    chk(mute == 1, "R11 mute in OFF", mute, 1);
    @(negedge clk);
    chk(done == 0, "R10 done one cycle", done, 0);
    // R4 gradual wake
    saw_ramp = 0;
    shutdown_n = 1'b1;
    wait_state(3);
    chk(saw_ramp, "R4 ramp-up seen", saw_ramp, 1);
    chk(gain_code == 31, "R4 wake final gain", gain_code, 31);
    chk(mute == 0, "R11 mute in ACTIVE", mute, 0);
    // R5 immediate shutdown
    fade_n = 1'b1;
    shutdown_n = 1'b0;
    @(negedge clk);
    chk(seq_state == 3'd5, "R5 immediate state", seq_state, 5);
    chk(gain_code == 0 && !bias_en, "R5 immediate gain/bias", gain_code, 0);
    wait_state(0);
    // R6 immediate wake
    pre_max = 0;
    shutdown_n = 1'b1;
    wait_state(3);
    chk(gain_code == 31, "R6 direct load", gain_code, 31);
    chk(pre_max == 0, "R6 no intermediate codes", pre_max, 0);
    // R7 single-ended ceiling
    se_sel = 1'b1;
    repeat (2) @(negedge clk);
    chk(se_mode && !neg_out_en, "R7 se flags", se_mode, 1);
    chk(gain_code == 28, "R7 se ceiling", gain_code, 28);
    se_sel = 1'b0;
    repeat (2) @(negedge clk);
    chk(gain_code == 31, "R7 back to bridged", gain_code, 31);
    // R9 reversal mid ramp-down
    fade_n = 1'b0;
    shutdown_n = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (gain_code <= 25) break;
    end
    shutdown_n = 1'b1;
    @(negedge clk);
    chk(seq_state == 3'd2, "R9 reversal to ramp-up", seq_state, 2);
    chk(gain_code == 25, "R9 reversal keeps code", gain_code, 25);
    wait_state(3);
    chk(gain_code == 31, "R9 reversal final", gain_code, 31);
    repeat (4) @(negedge clk);
    summary();
  end

endmodule